// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound path of a host bridge and rewrites each request address from the local bus into the address used on the PCIe side. It holds a set of programmable windows. Each window is described by a 64-bit match value, a 64-bit remap value, a 64-bit mask and a transaction-type code. Bit 0 of the low match word enables the window. A request whose masked address equals the window's masked match value takes the remap value in the masked bits, and keeps its own address in the unmasked bits. The request is then tagged with that window's type code.

When no enabled window hits, the request passes through with its address unchanged and carries the type held in a separate default actions register. Translation can be switched off as a whole with `xlate_en`. Requests that come from the configuration port (`req_cfg`) skip translation while `cfg_bypass` is set. Windows are programmed through a simple write port. Results leave through a one-entry registered output stage, with a valid/ready handshake on the request side and on the response side.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1. Every window register and the default actions register reset to zero, so no window is enabled and a miss carries type 0x0.
- R2: Window w (0..7) occupies byte offsets w*0x20 + {0x00 match low, 0x04 match high, 0x08 remap low, 0x0C remap high, 0x10 mask low, 0x14 mask high, 0x18 actions}. The default actions register sits at 0xFC. A write with `reg_addr[1:0]` not zero, or to offset 0x1C of windows 0..6, changes nothing.
- R3: An enabled window hits address A when (A AND M) equals (match AND M), where M is the mask with bits 15:0 forced to zero. Written mask bits 15:0 have no effect.
- R4: On a hit, the output address is (remap AND M) OR (A AND NOT M). Remap bits outside M have no effect, and address bits 15:0 always pass through unchanged.
- R5: On a hit, `rsp_type` is bits 3:0 of that window's actions register, `rsp_hit` is 1 and `rsp_win` is the window index. Type codes: 0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message.
- R6: When several enabled windows hit, the lowest-numbered one is used.
- R7: When no enabled window hits, `rsp_addr` equals A, `rsp_type` is bits 3:0 of the default actions register, `rsp_hit` is 0 and `rsp_win` is 0.
- R8: With `xlate_en` low, every request is handled as a miss (R7).
- R9: A request with `req_cfg` high is handled as a miss while `cfg_bypass` is high. With `cfg_bypass` low, or with `req_cfg` low, the request is translated normally.
- R10: A window whose enable bit (match low bit 0) is 0 never hits, even when its masked match value equals the request's masked address.
- R11: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. An accepted request appears on the response outputs one cycle later. While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold their values. The result uses the register contents of the cycle in which the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Global window translation enable |
| cfg_bypass | input | 1 | Skip translation for configuration-port requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 64 | Request address |
| req_cfg | input | 1 | Request comes from the configuration port |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_addr | output | 64 | Translated address |
| rsp_type | output | 4 | Transaction type code |
| rsp_hit | output | 1 | A window hit (0 means the default path) |
| rsp_win | output | 3 | Index of the window that hit |

## Verification
A corrupted window register shows up at the ports on the first response to an address inside that window, as a wrong remapped high part or type code. A corrupted enable or priority choice shows up as a wrong `rsp_hit` or `rsp_win` on that same response, one cycle after the request is accepted. A fault in the output stage shows up as a response that changes while stalled, or as a `req_ready` that disagrees with the handshake rule in the very cycle it occurs. The reference model tracks every register write and every accepted request, so each of these faults is caught on the first clock where it becomes visible.

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int NWIN = 8,
  parameter int AW   = 64,
  parameter int DW   = 32,
  localparam int WIDX   = $clog2(NWIN),
  localparam int REG_AW = WIDX + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic              cfg_bypass,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_cfg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [AW-1:0]     rsp_addr,
  output logic [3:0]        rsp_type,
  output logic              rsp_hit,
  output logic [WIDX-1:0]   rsp_win
);
  localparam int HIW = AW - DW;

  logic [DW-1:16]  m_lo [NWIN];
  logic            m_en [NWIN];
  logic [HIW-1:0]  m_hi [NWIN];
  logic [DW-1:16]  r_lo [NWIN];
  logic [HIW-1:0]  r_hi [NWIN];
  logic [DW-1:16]  k_lo [NWIN];
  logic [HIW-1:0]  k_hi [NWIN];
  logic [3:0]      act  [NWIN];
  logic [3:0]      def_act;

  logic [AW-1:0]   w_match [NWIN];
  logic [AW-1:0]   w_remap [NWIN];
  logic [AW-1:0]   w_mask  [NWIN];
  logic [NWIN-1:0] hit_w;

  logic wr_ok;
  assign wr_ok = reg_we && (reg_addr[1:0] == 2'b00);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic sel_w;
    assign sel_w = wr_ok && (reg_addr[REG_AW-1:5] == WIDX'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m_lo[w] <= '0; m_en[w] <= 1'b0; m_hi[w] <= '0;
        r_lo[w] <= '0; r_hi[w] <= '0;
        k_lo[w] <= '0; k_hi[w] <= '0;
        act[w]  <= '0;
      end else if (sel_w) begin
        case (reg_addr[4:2])
          3'd0: begin m_lo[w] <= reg_wdata[DW-1:16]; m_en[w] <= reg_wdata[0]; end
          3'd1: m_hi[w] <= reg_wdata[HIW-1:0];
          3'd2: r_lo[w] <= reg_wdata[DW-1:16];
          3'd3: r_hi[w] <= reg_wdata[HIW-1:0];
          3'd4: k_lo[w] <= reg_wdata[DW-1:16];
          3'd5: k_hi[w] <= reg_wdata[HIW-1:0];
          3'd6: act[w]  <= reg_wdata[3:0];
          default: ;
        endcase
      end
    end

    assign w_match[w] = {m_hi[w], m_lo[w], 16'h0};
    assign w_remap[w] = {r_hi[w], r_lo[w], 16'h0};
    assign w_mask[w]  = {k_hi[w], k_lo[w], 16'h0};
    assign hit_w[w]   = m_en[w] && (((req_addr ^ w_match[w]) & w_mask[w]) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      def_act <= '0;
    else if (wr_ok && reg_addr == REG_AW'(NWIN * 32 - 4))
      def_act <= reg_wdata[3:0];
  end

  logic [WIDX-1:0] sel;
  always_comb begin
    sel = '0;
    for (int w = NWIN - 1; w >= 0; w--)
      if (hit_w[w]) sel = WIDX'(w);
  end

  logic do_xl;
  assign do_xl = xlate_en && !(req_cfg && cfg_bypass) && (|hit_w);

  logic fire;
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_type  <= '0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= do_xl ? ((w_remap[sel] & w_mask[sel]) | (req_addr & ~w_mask[sel])) : req_addr;
      rsp_type  <= do_xl ? act[sel] : def_act;
      rsp_hit   <= do_xl;
      rsp_win   <= do_xl ? sel : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_type)
      && $stable(rsp_hit) && $stable(rsp_win));

  // R4
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_addr[15:0] == $past(req_addr[15:0]));

  // R7
  miss_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_win == '0);

  // R8
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !xlate_en |=> !rsp_hit && rsp_addr == $past(req_addr));

  // R9
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_cfg && cfg_bypass |=> !rsp_hit && rsp_addr == $past(req_addr));
endmodule

// File: tb/sim_addr_window_xlate.sv
module sim_addr_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b1, cfg_bypass = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0, req_cfg = 1'b0, rsp_ready = 1'b1;
  logic [63:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_hit;
  logic [63:0] rsp_addr;
  logic [3:0]  rsp_type;
  logic [2:0]  rsp_win;

  always #10 clk = ~clk;

  addr_window_xlate u0 (.*);

  int errors = 0, checks = 0;
  string cur = "R1";
  bit done = 1'b0;

  bit [63:0] bm_match [8], bm_remap [8], bm_mask [8];
  bit [3:0]  bm_act [8];
  bit [3:0]  bm_def;
  bit        e_valid, e_hit;
  bit [63:0] e_addr;
  bit [3:0]  e_type;
  bit [2:0]  e_win;

  task automatic chk(bit ok, string what, string act_s, string exp_s);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%s expected=%s", cur, what, act_s, exp_s);
    end
  endtask

  task automatic model_xlate(bit [63:0] a, bit cfg, output bit [63:0] oa,
                             output bit [3:0] ot, output bit oh, output bit [2:0] ow);
    oa = a; ot = bm_def; oh = 0; ow = 0;
    if (xlate_en && !(cfg && cfg_bypass)) begin
      for (int w = 7; w >= 0; w--) begin
        bit [63:0] mk;
        mk = bm_mask[w] & ~64'hFFFF;
        if (bm_match[w][0] && (((a ^ bm_match[w]) & mk) == 0)) begin
          oa = (bm_remap[w] & mk) | (a & ~mk);
          ot = bm_act[w]; oh = 1; ow = 3'(w);
        end
      end
    end
  endtask

  task automatic model_write(bit [7:0] a, bit [31:0] d);
    int w;
    w = a[7:5];
    if (a[1:0] != 0) return;
    case (a[4:2])
      0: bm_match[w][31:0]  = d;
      1: bm_match[w][63:32] = d;
      2: bm_remap[w][31:0]  = d;
      3: bm_remap[w][63:32] = d;
      4: bm_mask[w][31:0]   = d;
      5: bm_mask[w][63:32]  = d;
      6: bm_act[w]          = d[3:0];
      7: if (w == 7) bm_def = d[3:0];
    endcase
  endtask

  task automatic tick();
    bit fire, rd;
    #1;
    rd = !e_valid || rsp_ready;
    chk(req_ready == rd, "req_ready", $sformatf("%0b", req_ready), $sformatf("%0b", rd));
    fire = req_valid && rd;
    if (fire) begin
      model_xlate(req_addr, req_cfg, e_addr, e_type, e_hit, e_win);
      e_valid = 1;
    end else if (rsp_ready) e_valid = 0;
    if (reg_we) model_write(reg_addr, reg_wdata);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == e_valid && (!e_valid ||
        (rsp_addr == e_addr && rsp_type == e_type && rsp_hit == e_hit && rsp_win == e_win)),
        "response",
        $sformatf("v%0b a%h t%h h%0b w%0d", rsp_valid, rsp_addr, rsp_type, rsp_hit, rsp_win),
        $sformatf("v%0b a%h t%h h%0b w%0d", e_valid, e_addr, e_type, e_hit, e_win));
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic set_win(int w, bit [63:0] m, bit [63:0] r, bit [63:0] k, bit [3:0] t);
    bit [7:0] b;
    b = 8'(w * 32);
    wr(b + 8'h00, m[31:0]);  wr(b + 8'h04, m[63:32]);
    wr(b + 8'h08, r[31:0]);  wr(b + 8'h0C, r[63:32]);
    wr(b + 8'h10, k[31:0]);  wr(b + 8'h14, k[63:32]);
    wr(b + 8'h18, {28'h0, t});
  endtask

  task automatic expect_req(bit [63:0] a, bit cfg, bit [63:0] xa, bit [3:0] xt, bit xh, bit [2:0] xw);
    req_valid = 1; req_addr = a; req_cfg = cfg; rsp_ready = 1;
    tick();
    req_valid = 0; req_cfg = 0;
    chk(rsp_valid && rsp_addr == xa && rsp_type == xt && rsp_hit == xh && rsp_win == xw,
        "directed",
        $sformatf("v%0b a%h t%h h%0b w%0d", rsp_valid, rsp_addr, rsp_type, rsp_hit, rsp_win),
        $sformatf("v1 a%h t%h h%0b w%0d", xa, xt, xh, xw));
    tick();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [63:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur = "R1";
    #1;
    chk(!rsp_valid && req_ready, "reset", $sformatf("%0b%0b", rsp_valid, req_ready), "01");
    @(negedge clk);
    expect_req(64'h0000_0001_2345_6789, 0, 64'h0000_0001_2345_6789, 4'h0, 0, 0);

    // R10 disabled window with matching value never hits
    cur = "R10";
    set_win(1, 64'h0000_0001_2340_0000, 64'h0000_0009_0000_0000, 64'hFFFF_FFFF_FFF0_0000, 4'hC);
    expect_req(64'h0000_0001_2345_6789, 0, 64'h0000_0001_2345_6789, 4'h0, 0, 0);

    // R2 R4 window 0, I/O type, junk remap bits outside mask
    cur = "R2";
    set_win(0, 64'h0000_0001_2340_0001, 64'h0000_0000_800F_1234, 64'hFFFF_FFFF_FFF0_0000, 4'h4);
    wr(8'h1C, 32'h0000_000C);
    wr(8'h01, 32'h0);
    cur = "R4";
    expect_req(64'h0000_0001_2345_6789, 0, 64'h0000_0000_8005_6789, 4'h4, 1, 0);
    cur = "R7";
    expect_req(64'h0000_0001_2450_0000, 0, 64'h0000_0001_2450_0000, 4'h0, 0, 0);

    // R3 mask low bits written as ones have no effect; R5 types
    cur = "R3";
    set_win(3, 64'h0000_0000_D000_0001, 64'h0000_0010_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 4'h8);
    expect_req(64'h0000_0000_D000_1234, 0, 64'h0000_0010_0000_1234, 4'h8, 1, 3);
    expect_req(64'h0000_0000_D001_1234, 0, 64'h0000_0000_D001_1234, 4'h0, 0, 0);
    cur = "R5";
    set_win(5, 64'h0000_0002_0000_0001, 64'h0000_0003_0000_0000, 64'hFFFF_FFFF_0000_0000, 4'hC);
    expect_req(64'h0000_0002_1234_5678, 0, 64'h0000_0003_1234_5678, 4'hC, 1, 5);
    set_win(7, 64'h0000_0000_E000_0001, 64'h0, 64'hFFFF_FFFF_F000_0000, 4'h9);
    expect_req(64'h0000_0000_E123_4567, 0, 64'h0000_0000_0123_4567, 4'h9, 1, 7);

    // R6 lowest index wins
    cur = "R6";
    set_win(2, 64'h0000_0002_1230_0001, 64'h0000_0000_4000_0000, 64'hFFFF_FFFF_FFF0_0000, 4'h0);
    expect_req(64'h0000_0002_1234_5678, 0, 64'h0000_0000_4004_5678, 4'h0, 1, 2);

    // R7 default actions register
    cur = "R7";
    wr(8'hFC, 32'h0000_0009);
    expect_req(64'h0000_0000_1111_0000, 0, 64'h0000_0000_1111_0000, 4'h9, 0, 0);

    // R8 global disable
    cur = "R8";
    xlate_en = 0;
    expect_req(64'h0000_0000_D000_1234, 0, 64'h0000_0000_D000_1234, 4'h9, 0, 0);
    xlate_en = 1;

    // R9 config-port bypass
    cur = "R9";
    cfg_bypass = 1;
    expect_req(64'h0000_0000_D000_1234, 1, 64'h0000_0000_D000_1234, 4'h9, 0, 0);
    expect_req(64'h0000_0000_D000_1234, 0, 64'h0000_0010_0000_1234, 4'h8, 1, 3);
    cfg_bypass = 0;
    expect_req(64'h0000_0000_D000_1234, 1, 64'h0000_0010_0000_1234, 4'h8, 1, 3);

    // R10 clearing the enable bit stops hits
    cur = "R10";
    wr(8'h00, 32'h2340_0000);
    expect_req(64'h0000_0001_2345_6789, 0, 64'h0000_0001_2345_6789, 4'h9, 0, 0);

    // R11 stall holds outputs
    cur = "R11";
    req_valid = 1; req_addr = 64'h0000_0000_E000_0010; rsp_ready = 0;
    tick();
    req_addr = 64'h0000_0002_0000_0020;
    tick(); tick(); tick();
    rsp_ready = 1;
    tick();
    req_valid = 0;
    tick();

    // R11 random traffic with handshake pressure
    lf = 64'hACE1_2345_6789_BEEF;
    for (int i = 0; i < 3000; i++) begin
      bit [63:0] base;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      case (lf[3:1])
        0: base = 64'h0000_0000_D000_0000;
        1: base = 64'h0000_0002_1230_0000;
        2: base = 64'h0000_0002_8000_0000;
        3: base = 64'h0000_0000_E000_0000;
        default: base = {lf[63:16], 16'h0};
      endcase
      req_addr   = base | {44'h0, lf[27:8]};
      req_valid  = lf[5] | lf[9];
      rsp_ready  = lf[6] | lf[12];
      req_cfg    = lf[7];
      cfg_bypass = lf[11] & lf[13];
      xlate_en   = !(lf[14] & lf[15] & lf[16]);
      tick();
    end
    req_valid = 0; rsp_ready = 1;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule